// File: doc/BRIEF.md
# Serial-Bus Control Port for a Frequency Synthesizer

This block is the digital control port of a tuner frequency synthesizer. It acts as an I2C slave, oversampling SCL and SDA with the core clock. A controller programs the synthesizer by writing one fixed frame: an address byte followed by four data bytes. Together these carry the main divider ratio, the reference divider select, the charge-pump current, the prescaler enable, the reference-output select, the test-mode bits and four general-purpose port bits. The new settings reach the outputs as one update, at the STOP that closes a complete frame.

A read returns a status byte. It holds a power-on flag, the loop lock level, a five-level ADC result and the levels of three input ports. The power-on flag is set by reset and drops once a status byte has been shifted out. The low two bits of the slave address come from a strap input, so four synthesizers can share one bus.

Top module: `synth_ctl_i2c`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal `{ADDR_BASE[6:2], addr_strap}` (default base 7'b1100000). Bit 0 is the read flag (1 = read). For any other address it drives nothing until the next START, and its fields stay unchanged.
- R2: After an acknowledged write address, the four data bytes are each acknowledged and map onto the fields as follows:
  - data byte 1 = main_ratio[16:9]
  - data byte 2 = main_ratio[8:1]
  - data byte 3 = {main_ratio[0], pump_sel[1:0], prescale_en, ref_sel[3:0]}
  - data byte 4 = {port_out[3:0], refout_sel[1:0], test_sel[1:0]}
  All fields change together at the STOP that follows, and not before it.
- R3: A write frame that reaches STOP with fewer than four data bytes leaves every field unchanged.
- R4: A read returns the status byte {por, lock_i, adc, port_in[2:0]}, MSB first. The master may acknowledge to receive it again.
- R5: adc_level values 0 to 4 are reported as they are. Any value above 4 is reported as 4.
- R6: The power-on flag (status bit 7) is 1 after reset. It is 0 in every status byte loaded after one status byte has been fully sent.
- R7: After reset, all fields are 0 and sda_oe is 0.
- R8: A data byte beyond the fourth is not acknowledged and is ignored. The frame still commits the first four data bytes at STOP.
- R9: The slave changes sda_oe only while SCL is low. It works at both SCL half-periods of 20 and 8 clocks (bus clocks up to clk/16).
- R10: A repeated START discards an unfinished write frame and begins a new one. A complete frame after it commits normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_strap | input | 2 | Low two bits of the slave address |
| port_in | input | 3 | Input port levels for the status byte |
| adc_level | input | 3 | ADC comparator result |
| lock_i | input | 1 | Loop in-lock level |
| main_ratio | output | 17 | Main divider ratio |
| ref_sel | output | 4 | Reference divider select |
| pump_sel | output | 2 | Charge-pump current select |
| prescale_en | output | 1 | Divide-by-two prescaler enable |
| refout_sel | output | 2 | Reference output source select |
| test_sel | output | 2 | Test-mode select |
| port_out | output | 4 | General-purpose output port bits |

## Verification
The hardest case to reach is a frame that is broken off: a write that is cut short by STOP or by a repeated START after a partial set of bytes, or one that runs past its fourth data byte. Here the fields must keep their old values, or take the values of the first four data bytes only. The bench reaches these cases by emitting START, byte and STOP symbols from separate tasks, so it can place a STOP or a repeated START after any byte count. It then reads the fields right after the STOP. The power-on flag is checked across two status bytes of one read, so the clear that happens between them is observed.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
    localparam int DATA_BYTES = 4;
    localparam int STAGE_W    = DATA_BYTES * 8;
    localparam int MAIN_W     = 17;
    localparam logic [2:0] ADC_MAX = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK_WAIT, ST_ACK_HOLD, ST_TX, ST_TX_ACK
    } fr_state_e;

    typedef struct packed {
        fr_state_e          state;
        logic [2:0]         bitcnt;
        logic [2:0]         bytecnt;
        logic [7:0]         sh;
        logic [STAGE_W-1:0] stage;
        logic               full;
        logic               rw;
        logic               nack;
        logic               oe;
        logic               commit;
        logic               rd_done;
        logic               scl_p;
        logic               sda_p;
    } fr_regs_t;

    typedef struct packed {
        logic [MAIN_W-1:0] main_ratio;
        logic [3:0]        ref_sel;
        logic [1:0]        pump_sel;
        logic              prescale_en;
        logic [1:0]        refout_sel;
        logic [1:0]        test_sel;
        logic [3:0]        port_out;
    } ctl_fields_t;
endpackage

// File: rtl/synth_ctl_sync.sv
module synth_ctl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES-1:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-2:0], din[g]};
        end
        assign dout[g] = pipe_q[STAGES-1];
    end
endmodule

// File: rtl/synth_ctl_frame.sv
module synth_ctl_frame
    import synth_ctl_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE = 7'b1100000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl,
    input  logic               sda,
    input  logic [1:0]         strap,
    input  logic [7:0]         status,
    output logic               sda_oe,
    output logic               commit,
    output logic               rd_done,
    output logic [STAGE_W-1:0] stage
);
    fr_regs_t q, d;
    logic scl_rise, scl_fall, start_c, stop_c;
    logic [6:0] my_addr;
    logic [7:0] byte_w;

    always_comb begin
        scl_rise = scl & ~q.scl_p;
        scl_fall = ~scl & q.scl_p;
        start_c  = scl & q.scl_p & q.sda_p & ~sda;
        stop_c   = scl & q.scl_p & ~q.sda_p & sda;
        my_addr  = {ADDR_BASE[6:2], strap};
        byte_w   = {q.sh[6:0], sda};

        d         = q;
        d.commit  = 1'b0;
        d.rd_done = 1'b0;
        d.scl_p   = scl;
        d.sda_p   = sda;

        if (start_c) begin
            d.state   = ST_RX;
            d.bitcnt  = '0;
            d.bytecnt = '0;
            d.full    = 1'b0;
            d.rw      = 1'b0;
            d.oe      = 1'b0;
        end else if (stop_c) begin
            d.state  = ST_IDLE;
            d.oe     = 1'b0;
            d.commit = q.full & ~q.rw;
            d.full   = 1'b0;
        end else begin
            case (q.state)
                ST_RX: if (scl_rise) begin
                    d.sh = byte_w;
                    if (q.bitcnt == 3'd7) begin
                        d.bitcnt = '0;
                        if (q.bytecnt == 3'd0) begin
                            if (byte_w[7:1] == my_addr) begin
                                d.rw    = byte_w[0];
                                d.state = ST_ACK_WAIT;
                            end else begin
                                d.state = ST_IDLE;
                            end
                        end else if (q.bytecnt <= 3'(DATA_BYTES)) begin
                            for (int i = 0; i < DATA_BYTES; i++) begin
                                if (q.bytecnt == 3'(i + 1))
                                    d.stage[(DATA_BYTES-1-i)*8 +: 8] = byte_w;
                            end
                            if (q.bytecnt == 3'(DATA_BYTES)) d.full = 1'b1;
                            d.state = ST_ACK_WAIT;
                        end else begin
                            d.state = ST_IDLE;
                        end
                        d.bytecnt = q.bytecnt + 3'd1;
                    end else begin
                        d.bitcnt = q.bitcnt + 3'd1;
                    end
                end
                ST_ACK_WAIT: if (scl_fall) begin
                    d.oe    = 1'b1;
                    d.state = ST_ACK_HOLD;
                end
                ST_ACK_HOLD: if (scl_fall) begin
                    d.bitcnt = '0;
                    if (q.rw) begin
                        d.state = ST_TX;
                        d.sh    = status;
                        d.oe    = ~status[7];
                    end else begin
                        d.state = ST_RX;
                        d.oe    = 1'b0;
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (q.bitcnt == 3'd7) begin
                        d.oe      = 1'b0;
                        d.state   = ST_TX_ACK;
                        d.rd_done = 1'b1;
                    end else begin
                        d.sh     = {q.sh[6:0], 1'b0};
                        d.oe     = ~q.sh[6];
                        d.bitcnt = q.bitcnt + 3'd1;
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) d.nack = sda;
                    if (scl_fall) begin
                        if (!q.nack) begin
                            d.state  = ST_TX;
                            d.sh     = status;
                            d.oe     = ~status[7];
                            d.bitcnt = '0;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign commit  = q.commit;
    assign rd_done = q.rd_done;
    assign stage   = q.stage;
endmodule

// File: rtl/synth_ctl_regs.sv
module synth_ctl_regs
    import synth_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic               rd_done,
    input  logic [STAGE_W-1:0] stage,
    input  logic [2:0]         port_in,
    input  logic [2:0]         adc_level,
    input  logic               lock_i,
    output ctl_fields_t        fields,
    output logic               por_flag,
    output logic [7:0]         status
);
    ctl_fields_t fields_d, fields_q;
    logic        por_d, por_q;
    logic [2:0]  adc_sat;

    always_comb begin
        fields_d = fields_q;
        por_d    = por_q;
        if (commit) begin
            fields_d.main_ratio  = stage[31:15];
            fields_d.pump_sel    = stage[14:13];
            fields_d.prescale_en = stage[12];
            fields_d.ref_sel     = stage[11:8];
            fields_d.port_out    = stage[7:4];
            fields_d.refout_sel  = stage[3:2];
            fields_d.test_sel    = stage[1:0];
        end
        if (rd_done) por_d = 1'b0;
        adc_sat = (adc_level > ADC_MAX) ? ADC_MAX : adc_level;
        status  = {por_q, lock_i, adc_sat, port_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= '0;
            por_q    <= 1'b1;
        end else begin
            fields_q <= fields_d;
            por_q    <= por_d;
        end
    end

    assign fields   = fields_q;
    assign por_flag = por_q;
endmodule

// File: rtl/synth_ctl_i2c.sv
module synth_ctl_i2c
    import synth_ctl_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE   = 7'b1100000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [1:0]  addr_strap,
    input  logic [2:0]  port_in,
    input  logic [2:0]  adc_level,
    input  logic        lock_i,
    output logic [16:0] main_ratio,
    output logic [3:0]  ref_sel,
    output logic [1:0]  pump_sel,
    output logic        prescale_en,
    output logic [1:0]  refout_sel,
    output logic [1:0]  test_sel,
    output logic [3:0]  port_out
);
    logic [1:0]         line_s;
    logic               commit, rd_done, por_flag;
    logic [STAGE_W-1:0] stage;
    logic [7:0]         status_byte;
    ctl_fields_t        fields;

    synth_ctl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(line_s)
    );

    synth_ctl_frame #(.ADDR_BASE(ADDR_BASE)) u_frame (
        .clk(clk), .rst_n(rst_n), .scl(line_s[1]), .sda(line_s[0]),
        .strap(addr_strap), .status(status_byte), .sda_oe(sda_oe),
        .commit(commit), .rd_done(rd_done), .stage(stage)
    );

    synth_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .rd_done(rd_done),
        .stage(stage), .port_in(port_in), .adc_level(adc_level),
        .lock_i(lock_i), .fields(fields), .por_flag(por_flag),
        .status(status_byte)
    );

    assign main_ratio  = fields.main_ratio;
    assign ref_sel     = fields.ref_sel;
    assign pump_sel    = fields.pump_sel;
    assign prescale_en = fields.prescale_en;
    assign refout_sel  = fields.refout_sel;
    assign test_sel    = fields.test_sel;
    assign port_out    = fields.port_out;
endmodule

// File: rtl/synth_ctl_chk.sv
module synth_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe,
    input logic        commit,
    input logic        rd_done,
    input logic        por_flag,
    input logic [16:0] main_ratio,
    input logic [3:0]  port_out,
    input logic [7:0]  status_byte
);
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    p_hold_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(main_ratio) && $stable(port_out)));

    p_por_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_flag) |-> $past(rd_done));

    p_adc_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[5:3] <= 3'd4);

    p_single_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({commit, rd_done}) <= 1);
endmodule

bind synth_ctl_i2c synth_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .commit(commit), .rd_done(rd_done), .por_flag(por_flag),
    .main_ratio(main_ratio), .port_out(port_out), .status_byte(status_byte)
);

// File: tb/synth_ctl_i2c_bench.sv
module synth_ctl_i2c_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_line;
    logic [1:0] addr_strap = 2'd2;
    logic [2:0] port_in = 3'd0, adc_level = 3'd0;
    logic lock_i = 1'b0;
    logic [16:0] main_ratio;
    logic [3:0] ref_sel, port_out;
    logic [1:0] pump_sel, refout_sel, test_sel;
    logic prescale_en;
    int hp = 20;
    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_fields;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    synth_ctl_i2c u_synth_ctl_i2c (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_strap(addr_strap), .port_in(port_in),
        .adc_level(adc_level), .lock_i(lock_i), .main_ratio(main_ratio),
        .ref_sel(ref_sel), .pump_sel(pump_sel), .prescale_en(prescale_en),
        .refout_sel(refout_sel), .test_sel(test_sel), .port_out(port_out)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_fields(input logic [7:0] b1, b2, b3, b4);
        return {b1, b2, b3, b4};
    endfunction

    function automatic logic [31:0] dut_fields();
        return {main_ratio, pump_sel, prescale_en, ref_sel, port_out, refout_sel, test_sel};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wt(hp); scl_m = 1'b1; wt(hp);
        sda_m = 1'b0; wt(hp); scl_m = 1'b0; wt(hp / 2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(hp); scl_m = 1'b1; wt(hp); sda_m = 1'b1; wt(hp);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(hp); scl_m = 1'b1; wt(hp); scl_m = 1'b0;
        end
        sda_m = 1'b1; wt(hp); scl_m = 1'b1; wt(hp / 2);
        ack = ~sda_line; wt(hp - hp / 2); scl_m = 1'b0;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(hp); scl_m = 1'b1; wt(hp / 2); b[i] = sda_line;
            wt(hp - hp / 2); scl_m = 1'b0;
        end
        sda_m = ~mack; wt(hp); scl_m = 1'b1; wt(hp); scl_m = 1'b0; wt(2);
        sda_m = 1'b1;
    endtask

    task automatic write_bytes(input logic [7:0] addr_b, input logic [31:0] data,
                               input int n, output int acks);
        logic a;
        acks = 0;
        send_byte(addr_b, a); if (a) acks++;
        for (int i = 0; i < n; i++) begin
            send_byte(data[31-8*(i%4) -: 8], a);
            if (a) acks++;
        end
    endtask

    task automatic t_reset();
        check("R7 fields", dut_fields(), 32'h0);
        check("R7 sda_oe", {31'h0, sda_oe}, 32'h0);
    endtask

    task automatic t_full_write();
        int acks;
        logic [31:0] v = pack_fields(8'hA5, 8'h3C, 8'h96, 8'hE1);
        bus_start();
        write_bytes(8'hC4, v, 4, acks);
        check("R1 R2 acks", acks, 5);
        check("R2 no update before STOP", dut_fields(), exp_fields);
        bus_stop(); wt(10);
        exp_fields = v;
        check("R2 fields", dut_fields(), exp_fields);
        check("R2 main_ratio", {15'h0, main_ratio}, {15'h0, 8'hA5, 8'h3C, 1'b1});
        check("R2 port_out", {28'h0, port_out}, 32'hE);
    endtask

    task automatic t_wrong_addr();
        int acks;
        bus_start();
        write_bytes(8'hC2, 32'h1122_3344, 4, acks);
        bus_stop(); wt(10);
        check("R1 no ack foreign addr", acks, 0);
        check("R1 fields unchanged", dut_fields(), exp_fields);
    endtask

    task automatic t_strap();
        int acks;
        logic [31:0] v = pack_fields(8'h01, 8'h80, 8'h7F, 8'h5A);
        addr_strap = 2'd1; wt(4);
        bus_start();
        write_bytes(8'hC2, v, 4, acks);
        bus_stop(); wt(10);
        exp_fields = v;
        check("R1 strap 1 acks", acks, 5);
        check("R1 strap 1 fields", dut_fields(), exp_fields);
        addr_strap = 2'd2; wt(4);
    endtask

    task automatic t_partial();
        int acks;
        bus_start();
        write_bytes(8'hC4, 32'hDEAD_BEEF, 3, acks);
        bus_stop(); wt(10);
        check("R3 partial acks", acks, 4);
        check("R3 fields unchanged", dut_fields(), exp_fields);
    endtask

    task automatic t_rstart();
        int acks;
        logic [31:0] v = pack_fields(8'h12, 8'h34, 8'h56, 8'h78);
        bus_start();
        write_bytes(8'hC4, 32'hFFFF_FFFF, 2, acks);
        bus_start();
        check("R10 no commit at restart", dut_fields(), exp_fields);
        write_bytes(8'hC4, v, 4, acks);
        bus_stop(); wt(10);
        exp_fields = v;
        check("R10 new frame commits", dut_fields(), exp_fields);
        bus_start();
        write_bytes(8'hC4, 32'h0F0F_0F0F, 2, acks);
        bus_start();
        bus_stop(); wt(10);
        check("R10 discarded frame", dut_fields(), exp_fields);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] b;
        port_in = 3'b101; lock_i = 1'b1; adc_level = 3'd2; wt(4);
        bus_start();
        send_byte(8'hC5, a);
        check("R4 read addr ack", {31'h0, a}, 32'h1);
        read_byte(1'b1, b);
        check("R4 R6 first status", {24'h0, b}, 32'hD5);
        read_byte(1'b0, b);
        check("R6 por cleared", {24'h0, b}, 32'h55);
        bus_stop(); wt(10);
        check("R4 read leaves fields", dut_fields(), exp_fields);
    endtask

    task automatic t_adc();
        logic a;
        logic [7:0] b;
        port_in = 3'b010; lock_i = 1'b0; adc_level = 3'd7; wt(4);
        bus_start(); send_byte(8'hC5, a); read_byte(1'b0, b); bus_stop();
        check("R5 adc saturates", {24'h0, b}, {24'h0, 2'b00, 3'd4, 3'b010});
        adc_level = 3'd4; wt(4);
        bus_start(); send_byte(8'hC5, a); read_byte(1'b0, b); bus_stop();
        check("R5 adc 4", {24'h0, b}, {24'h0, 2'b00, 3'd4, 3'b010});
    endtask

    task automatic t_extra();
        logic a;
        int acks;
        logic [31:0] v = pack_fields(8'h9A, 8'hBC, 8'hDE, 8'hF0);
        bus_start();
        write_bytes(8'hC4, v, 4, acks);
        send_byte(8'h00, a);
        check("R8 extra byte not acked", {31'h0, a}, 32'h0);
        bus_stop(); wt(10);
        exp_fields = v;
        check("R8 first four committed", dut_fields(), exp_fields);
    endtask

    task automatic t_fast();
        int acks;
        logic a;
        logic [7:0] b;
        logic [31:0] v = pack_fields(8'h55, 8'hAA, 8'h33, 8'hCC);
        hp = 8;
        bus_start();
        write_bytes(8'hC4, v, 4, acks);
        bus_stop(); wt(10);
        exp_fields = v;
        check("R9 fast acks", acks, 5);
        check("R9 fast fields", dut_fields(), exp_fields);
        port_in = 3'b011; lock_i = 1'b1; adc_level = 3'd1; wt(4);
        bus_start(); send_byte(8'hC5, a); read_byte(1'b0, b); bus_stop();
        check("R9 fast status", {24'h0, b}, 32'h4B);
        hp = 20;
    endtask

    initial begin
        exp_fields = '0;
        wt(5); rst_n = 1'b1; wt(5);
        t_reset();
        t_full_write();
        t_wrong_addr();
        t_strap();
        t_partial();
        t_rstart();
        t_read();
        t_adc();
        t_extra();
        t_fast();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wt(150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule